// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block is a single DMA channel that follows a chain of packed 8-byte descriptors in memory. For each descriptor it issues one transfer request, made of an address and a byte count, to an external data mover. Each descriptor is read in one 64-bit beat through a memory read port. Descriptors sit back to back, so the fetch pointer moves forward by 8 bytes for each entry. The walk ends after the entry that carries the end-of-list flag. At that point the block raises a one-cycle completion pulse for the interrupt aggregator.

A parameter sets the direction when the block is built. A transmit channel (memory to device) starts as soon as software writes the descriptor pointer. A receive channel (device to memory) only stores that pointer, and its walk starts from a separate enable bit. Clearing the enable bit stops a receive walk that is in progress. A receive channel also holds a bytes-per-row value for a downstream video path. A malformed descriptor ends the walk and sets a sticky error flag.

Top module: `sgw_channel`

## Requirements
- R1: After reset the channel is idle: `busy`, `mem_req`, `xfer_req`, `done` and `err` are all 0, and `row_bytes` is 0.
- R2: On a transmit channel, a write to offset 0x04 while idle starts a walk at the written address. On a receive channel, the same write only loads the pointer and starts nothing.
- R3: On a receive channel, a write to offset 0x14 with bit 0 set while idle starts a walk at the stored pointer. A transmit channel ignores offset 0x14.
- R4: During a fetch, `mem_req` stays high and `mem_addr` stays stable until `mem_valid`. The first fetch reads the start pointer, and each following fetch reads 8 bytes higher. The descriptor word has flags in bits 7:0, a zero byte in bits 15:8, the 16-bit length in bits 31:16 and the 32-bit address in bits 63:32. `mem_req` and `xfer_req` are never high together.
- R5: A descriptor with flags bit 0 (valid, 0x01) and bit 5 (transfer, 0x20) set raises `xfer_req` with its address and length. The request is held stable until `xfer_ack`.
- R6: A valid descriptor without the transfer flag issues no request. The walk goes on to the next entry, unless that descriptor is the last one.
- R7: Once the entry with flags bit 1 (last, 0x02) has finished, `done` pulses for exactly one cycle and the channel is idle in that same cycle. "Finished" means its `xfer_ack` has arrived, or its fetch has completed if it issues no transfer.
- R8: A fetched descriptor without the valid flag, or with a length whose two low bits are not both zero, ends the walk. The channel then goes idle with `err` = 1 and gives no `done` pulse. `err` stays set until the next start clears it.
- R9: On a receive channel, a write of 0 to bit 0 of offset 0x14 during a walk returns the channel to idle on the next cycle, with no `done` and no error.
- R10: On a receive channel, a write to offset 0x30 loads `row_bytes`. On a transmit channel, `row_bytes` stays 0.
- R11: A write to offset 0x04 during a walk is ignored. It neither restarts the walk nor changes the fetch sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Descriptor fetch request |
| mem_addr | output | ADDR_W | Descriptor fetch address |
| mem_valid | input | 1 | Descriptor word returned |
| mem_rdata | input | 64 | Descriptor word |
| xfer_req | output | 1 | Transfer request to data mover |
| xfer_addr | output | ADDR_W | Transfer address |
| xfer_len | output | 16 | Transfer byte count |
| xfer_ack | input | 1 | Data mover finished the transfer |
| done | output | 1 | One-cycle end-of-list pulse |
| err | output | 1 | Sticky malformed-descriptor flag |
| busy | output | 1 | A walk is in progress |
| row_bytes | output | ROW_W | Stored bytes-per-row value |

## Verification
The hardest case to reach from the ports is a receive walk stopped in the middle of a chain while the transmit twin keeps running the same chain. The bench places one receive instance and one transmit instance on a shared register bus and gives the memory and data-mover responders a latency of several cycles. The disable write therefore lands while a fetch or a transfer is still pending, and the receive side must drop its request without pulsing `done`. Other stimulus covers entries that carry no transfer, a last entry that carries no transfer, a misaligned length, a missing valid flag, an unmapped address, and a pointer rewrite during a walk.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

   typedef enum logic [1:0] {
      SG_IDLE  = 2'd0,
      SG_FETCH = 2'd1,
      SG_ISSUE = 2'd2
   } sg_state_e;

   // register byte offsets that software decodes
   localparam int OFS_PTR = 'h04;
   localparam int OFS_EN  = 'h14;
   localparam int OFS_ROW = 'h30;

   // descriptor geometry
   localparam int DESC_BYTES = 8;
   localparam int DESC_W     = 64;
   localparam int LEN_W      = 16;
   localparam int LEN_LSB    = 16;
   localparam int ADR_LSB    = 32;

   // flag bit positions in byte 0
   localparam int FLG_VALID = 0;
   localparam int FLG_LAST  = 1;
   localparam int FLG_XFER  = 5;

endpackage

// File: rtl/sgw_regs.sv
module sgw_regs
   import sgw_pkg::*;
#(
   parameter int IS_RX  = 1,
   parameter int REG_AW = 6,
   parameter int ADDR_W = 32,
   parameter int ROW_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              busy,
   output logic              start,
   output logic              stop,
   output logic [ADDR_W-1:0] start_ptr,
   output logic [ROW_W-1:0]  row_bytes
);

   localparam logic [REG_AW-1:0] A_PTR = REG_AW'(OFS_PTR);
   localparam logic [REG_AW-1:0] A_EN  = REG_AW'(OFS_EN);
   localparam logic [REG_AW-1:0] A_ROW = REG_AW'(OFS_ROW);

   logic hit_ptr, hit_en;
   assign hit_ptr = reg_wr && (reg_addr == A_PTR);
   assign hit_en  = reg_wr && (reg_addr == A_EN);

   generate
      if (IS_RX != 0) begin : g_rx
         logic [ADDR_W-1:0] ptr_q;
         logic [ROW_W-1:0]  row_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ptr_q <= '0;
               row_q <= '0;
            end else begin
               if (hit_ptr && !busy) ptr_q <= reg_wdata[ADDR_W-1:0];
               if (reg_wr && (reg_addr == A_ROW)) row_q <= reg_wdata[ROW_W-1:0];
            end
         end

         assign start     = hit_en && reg_wdata[0] && !busy;
         assign stop      = hit_en && !reg_wdata[0] && busy;
         assign start_ptr = ptr_q;
         assign row_bytes = row_q;
      end else begin : g_tx
         assign start     = hit_ptr && !busy;
         assign stop      = 1'b0;
         assign start_ptr = reg_wdata[ADDR_W-1:0];
         assign row_bytes = '0;
      end
   endgenerate

endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
   import sgw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int ALIGN_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic [ADDR_W-1:0] start_ptr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DESC_W-1:0] mem_rdata,
   output logic              xfer_req,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [LEN_W-1:0]  xfer_len,
   input  logic              xfer_ack,
   output logic              done,
   output logic              err,
   output logic              busy
);

   localparam int AL_W = $clog2(ALIGN_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

   sg_state_e         state;
   logic [ADDR_W-1:0] fa_q, xa_q;
   logic [LEN_W-1:0]  xl_q;
   logic              last_q, done_q, err_q;

   logic [7:0]        d_flags;
   logic [LEN_W-1:0]  d_len;
   logic [ADDR_W-1:0] d_addr;
   logic              d_bad;

   assign d_flags = mem_rdata[7:0];
   assign d_len   = mem_rdata[LEN_LSB +: LEN_W];
   assign d_addr  = mem_rdata[ADR_LSB +: ADDR_W];
   assign d_bad   = !d_flags[FLG_VALID] || (d_len[AL_W-1:0] != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SG_IDLE;
         fa_q   <= '0;
         xa_q   <= '0;
         xl_q   <= '0;
         last_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            SG_IDLE: begin
               if (start) begin
                  state <= SG_FETCH;
                  fa_q  <= start_ptr;
                  err_q <= 1'b0;
               end
            end
            SG_FETCH: begin
               if (stop) begin
                  state <= SG_IDLE;
               end else if (mem_valid) begin
                  if (d_bad) begin
                     err_q <= 1'b1;
                     state <= SG_IDLE;
                  end else if (d_flags[FLG_XFER]) begin
                     xa_q   <= d_addr;
                     xl_q   <= d_len;
                     last_q <= d_flags[FLG_LAST];
                     state  <= SG_ISSUE;
                  end else if (d_flags[FLG_LAST]) begin
                     done_q <= 1'b1;
                     state  <= SG_IDLE;
                  end else begin
                     fa_q <= fa_q + STEP;
                  end
               end
            end
            SG_ISSUE: begin
               if (stop) begin
                  state <= SG_IDLE;
               end else if (xfer_ack) begin
                  if (last_q) begin
                     done_q <= 1'b1;
                     state  <= SG_IDLE;
                  end else begin
                     fa_q  <= fa_q + STEP;
                     state <= SG_FETCH;
                  end
               end
            end
            default: state <= SG_IDLE;
         endcase
      end
   end

   assign mem_req   = (state == SG_FETCH);
   assign mem_addr  = fa_q;
   assign xfer_req  = (state == SG_ISSUE);
   assign xfer_addr = xa_q;
   assign xfer_len  = xl_q;
   assign done      = done_q;
   assign err       = err_q;
   assign busy      = (state != SG_IDLE);

endmodule

// File: rtl/sgw_channel.sv
module sgw_channel
   import sgw_pkg::*;
#(
   parameter int IS_RX       = 1,
   parameter int REG_AW      = 6,
   parameter int ADDR_W      = 32,
   parameter int ROW_W       = 16,
   parameter int ALIGN_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [63:0]       mem_rdata,
   output logic              xfer_req,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [15:0]       xfer_len,
   input  logic              xfer_ack,
   output logic              done,
   output logic              err,
   output logic              busy,
   output logic [ROW_W-1:0]  row_bytes
);

   generate
      if (REG_AW < 6 || REG_AW > 16) begin : g_bad_aw
         $error("sgw_channel: REG_AW must lie in 6..16");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("sgw_channel: ADDR_W must lie in 8..32");
      end
      if (ROW_W < 1 || ROW_W > 32) begin : g_bad_row
         $error("sgw_channel: ROW_W must lie in 1..32");
      end
      if (ALIGN_BYTES < 2 || (ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0) begin : g_bad_al
         $error("sgw_channel: ALIGN_BYTES must be a power of two of at least 2");
      end
   endgenerate

   logic              start, stop;
   logic [ADDR_W-1:0] start_ptr;

   sgw_regs #(
      .IS_RX (IS_RX),
      .REG_AW(REG_AW),
      .ADDR_W(ADDR_W),
      .ROW_W (ROW_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .busy     (busy),
      .start    (start),
      .stop     (stop),
      .start_ptr(start_ptr),
      .row_bytes(row_bytes)
   );

   sgw_walker #(
      .ADDR_W     (ADDR_W),
      .ALIGN_BYTES(ALIGN_BYTES)
   ) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .stop     (stop),
      .start_ptr(start_ptr),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .mem_valid(mem_valid),
      .mem_rdata(mem_rdata),
      .xfer_req (xfer_req),
      .xfer_addr(xfer_addr),
      .xfer_len (xfer_len),
      .xfer_ack (xfer_ack),
      .done     (done),
      .err      (err),
      .busy     (busy)
   );

endmodule

// File: rtl/sgw_chk.sv
module sgw_chk
   import sgw_pkg::*;
#(
   parameter int IS_RX  = 1,
   parameter int REG_AW = 6,
   parameter int ADDR_W = 32,
   parameter int ROW_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [REG_AW-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_valid,
   input logic [63:0]       mem_rdata,
   input logic              xfer_req,
   input logic [ADDR_W-1:0] xfer_addr,
   input logic [15:0]       xfer_len,
   input logic              xfer_ack,
   input logic              done,
   input logic              err,
   input logic              busy,
   input logic [ROW_W-1:0]  row_bytes
);

   logic stop_wr, tx_go;
   assign stop_wr = (IS_RX != 0) && reg_wr && (reg_addr == REG_AW'(OFS_EN)) && !reg_wdata[0];
   assign tx_go   = (IS_RX == 0) && reg_wr && (reg_addr == REG_AW'(OFS_PTR)) && !busy;

   // R4
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_valid && !stop_wr |=> mem_req && $stable(mem_addr));

   // R4
   one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && xfer_req));

   // R5
   xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_ack && !stop_wr |=> xfer_req && $stable(xfer_addr) && $stable(xfer_len));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy);

   // R9
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && stop_wr |=> !busy && !done);

   // R2
   tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |=> mem_req && (mem_addr == $past(reg_wdata[ADDR_W-1:0])));

endmodule

bind sgw_channel sgw_chk #(
   .IS_RX (IS_RX),
   .REG_AW(REG_AW),
   .ADDR_W(ADDR_W),
   .ROW_W (ROW_W)
) u_chk (.*);

// File: tb/tb_sgw_channel.sv
module tb_sgw_channel;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;

   // index 0 = receive instance, index 1 = transmit instance
   logic        mem_req   [2];
   logic [31:0] mem_addr  [2];
   logic        mem_valid [2];
   logic [63:0] mem_rdata [2];
   logic        xfer_req  [2];
   logic [31:0] xfer_addr [2];
   logic [15:0] xfer_len  [2];
   logic        xfer_ack  [2];
   logic        done      [2];
   logic        err       [2];
   logic        busy      [2];
   logic [15:0] row_bytes [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   sgw_channel #(.IS_RX(1)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .mem_req(mem_req[0]), .mem_addr(mem_addr[0]), .mem_valid(mem_valid[0]), .mem_rdata(mem_rdata[0]),
      .xfer_req(xfer_req[0]), .xfer_addr(xfer_addr[0]), .xfer_len(xfer_len[0]), .xfer_ack(xfer_ack[0]),
      .done(done[0]), .err(err[0]), .busy(busy[0]), .row_bytes(row_bytes[0]));

   sgw_channel #(.IS_RX(0)) dut_tx (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .mem_req(mem_req[1]), .mem_addr(mem_addr[1]), .mem_valid(mem_valid[1]), .mem_rdata(mem_rdata[1]),
      .xfer_req(xfer_req[1]), .xfer_addr(xfer_addr[1]), .xfer_len(xfer_len[1]), .xfer_ack(xfer_ack[1]),
      .done(done[1]), .err(err[1]), .busy(busy[1]), .row_bytes(row_bytes[1]));

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // descriptor memory
   logic [63:0] dmem [int];

   function automatic logic [63:0] mk(input logic [7:0] fl, input logic [15:0] ln, input logic [31:0] ad);
      return {ad, ln, 8'h00, fl};
   endfunction

   // behavioural reference model, one slot per instance
   int          m_st   [2];
   logic [31:0] m_ptr  [2];
   logic [31:0] m_fa   [2];
   logic [31:0] m_xa   [2];
   logic [15:0] m_xl   [2];
   logic        m_last [2];
   logic        m_done [2];
   logic        m_err  [2];
   logic [15:0] m_row  [2];
   int          xfer_cnt [2];
   int          done_cnt [2];

   always @(posedge clk) begin
      cyc++;
      for (int c = 0; c < 2; c++) begin
         automatic logic rx = (c == 0);
         automatic logic wp = reg_wr && (reg_addr == 6'h04);
         automatic logic we = reg_wr && (reg_addr == 6'h14);
         automatic logic [63:0] d = mem_rdata[c];
         if (rst_n) begin
            if (xfer_req[c] && xfer_ack[c]) xfer_cnt[c]++;
            if (done[c]) done_cnt[c]++;
         end
         if (!rst_n) begin
            m_st[c] = 0; m_ptr[c] = 0; m_fa[c] = 0; m_xa[c] = 0; m_xl[c] = 0;
            m_last[c] = 0; m_done[c] = 0; m_err[c] = 0; m_row[c] = 0;
         end else begin
            m_done[c] = 0;
            if (rx && reg_wr && reg_addr == 6'h30) m_row[c] = reg_wdata[15:0];
            case (m_st[c])
               0: begin
                  if (rx && wp) m_ptr[c] = reg_wdata;
                  if (rx ? (we && reg_wdata[0]) : wp) begin
                     m_st[c] = 1;
                     m_fa[c] = rx ? m_ptr[c] : reg_wdata;
                     m_err[c] = 0;
                  end
               end
               1: begin
                  if (rx && we && !reg_wdata[0]) m_st[c] = 0;
                  else if (mem_valid[c]) begin
                     if (!d[0] || d[17:16] != 2'b00) begin m_err[c] = 1; m_st[c] = 0; end
                     else if (d[5]) begin
                        m_xa[c] = d[63:32]; m_xl[c] = d[31:16]; m_last[c] = d[1]; m_st[c] = 2;
                     end
                     else if (d[1]) begin m_done[c] = 1; m_st[c] = 0; end
                     else m_fa[c] = m_fa[c] + 8;
                  end
               end
               default: begin
                  if (rx && we && !reg_wdata[0]) m_st[c] = 0;
                  else if (xfer_ack[c]) begin
                     if (m_last[c]) begin m_done[c] = 1; m_st[c] = 0; end
                     else begin m_fa[c] = m_fa[c] + 8; m_st[c] = 1; end
                  end
               end
            endcase
         end
      end
   end

   // per-cycle comparison, then responders (memory and data mover)
   int mem_lat [2] = '{1, 2};
   int ack_lat [2] = '{2, 1};
   int mcnt [2] = '{0, 0};
   int acnt [2] = '{0, 0};

   initial begin
      for (int c = 0; c < 2; c++) begin
         mem_valid[c] = 0; mem_rdata[c] = '0; xfer_ack[c] = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && cyc > 1) begin
         for (int c = 0; c < 2; c++) begin
            check(busy[c] == (m_st[c] != 0), "R4 busy", busy[c], m_st[c] != 0);
            check(mem_req[c] == (m_st[c] == 1), "R4 mem_req", mem_req[c], m_st[c] == 1);
            if (m_st[c] == 1) check(mem_addr[c] == m_fa[c], "R4 mem_addr", mem_addr[c], m_fa[c]);
            check(xfer_req[c] == (m_st[c] == 2), "R5 xfer_req", xfer_req[c], m_st[c] == 2);
            if (m_st[c] == 2) begin
               check(xfer_addr[c] == m_xa[c], "R5 xfer_addr", xfer_addr[c], m_xa[c]);
               check(xfer_len[c] == m_xl[c], "R5 xfer_len", xfer_len[c], m_xl[c]);
            end
            check(done[c] == m_done[c], "R7 done", done[c], m_done[c]);
            check(err[c] == m_err[c], "R8 err", err[c], m_err[c]);
            check(row_bytes[c] == m_row[c], "R10 row_bytes", row_bytes[c], m_row[c]);
         end
      end
      for (int c = 0; c < 2; c++) begin
         if (mem_req[c] === 1'b1) begin
            if (mcnt[c] >= mem_lat[c]) begin
               mem_valid[c] = 1;
               mem_rdata[c] = dmem.exists(int'(mem_addr[c])) ? dmem[int'(mem_addr[c])] : 64'h0;
               mcnt[c] = 0;
            end else begin
               mem_valid[c] = 0; mcnt[c]++;
            end
         end else begin
            mem_valid[c] = 0; mcnt[c] = 0;
         end
         if (xfer_req[c] === 1'b1) begin
            if (acnt[c] >= ack_lat[c]) begin xfer_ack[c] = 1; acnt[c] = 0; end
            else begin xfer_ack[c] = 0; acnt[c]++; end
         end else begin
            xfer_ack[c] = 0; acnt[c] = 0;
         end
      end
   end

   task automatic wr(input logic [5:0] a, input logic [31:0] v);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic wait_idle(input int c);
      while (m_st[c] != 0) @(negedge clk);
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      if (cyc > WATCHDOG) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   int x0, d0, x1, d1;

   initial begin
      // list A: transfer, skip entry, last transfer
      dmem[32'h100] = mk(8'h21, 16'h0040, 32'h8000_0000);
      dmem[32'h108] = mk(8'h01, 16'h0000, 32'h0);
      dmem[32'h110] = mk(8'h23, 16'h0010, 32'h1234_5678);
      // list B: single last entry, zero length
      dmem[32'h200] = mk(8'h23, 16'h0000, 32'hAAAA_0000);
      // list C: misaligned length; list D: missing valid flag
      dmem[32'h300] = mk(8'h21, 16'h0006, 32'h0);
      dmem[32'h400] = mk(8'h20, 16'h0010, 32'h0);
      // list E: five transfers, the last with the largest aligned length
      for (int i = 0; i < 4; i++) dmem[32'h500 + 8*i] = mk(8'h21, 16'(16*(i+1)), 32'h4000_0000 + 32'(i*'h100));
      dmem[32'h520] = mk(8'h23, 16'hFFFC, 32'h5000_0000);
      // list F: last entry that carries no transfer
      dmem[32'h600] = mk(8'h03, 16'h0000, 32'h0);

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
         check(!busy[c] && !mem_req[c] && !xfer_req[c], "R1 idle", busy[c], 0);
         check(!done[c] && !err[c] && row_bytes[c] == 0, "R1 flags", {done[c], err[c]}, 0);
      end

      // R2 transmit starts on pointer write, receive does not
      x1 = xfer_cnt[1]; d1 = done_cnt[1];
      wr(6'h04, 32'h100);
      check(busy[1] == 1, "R2 tx started", busy[1], 1);
      check(busy[0] == 0, "R2 rx not started", busy[0], 0);
      wait_idle(1);
      check(xfer_cnt[1] - x1 == 2, "R6 skip entry issues nothing", xfer_cnt[1] - x1, 2);
      check(done_cnt[1] - d1 == 1, "R7 one done", done_cnt[1] - d1, 1);

      // R3 receive starts on enable from stored pointer
      x0 = xfer_cnt[0]; d0 = done_cnt[0];
      wr(6'h14, 32'h1);
      check(busy[0] == 1, "R3 rx started", busy[0], 1);
      check(busy[1] == 0, "R3 tx ignores enable", busy[1], 0);
      wait_idle(0);
      check(xfer_cnt[0] - x0 == 2 && done_cnt[0] - d0 == 1, "R3 rx walk", xfer_cnt[0] - x0, 2);

      // R10 bytes-per-row
      wr(6'h30, 32'h280);
      check(row_bytes[0] == 16'h280, "R10 rx row", row_bytes[0], 16'h280);
      check(row_bytes[1] == 0, "R10 tx row", row_bytes[1], 0);

      // R8 misaligned length and missing valid flag
      mem_lat = '{0, 0};
      d0 = done_cnt[0]; d1 = done_cnt[1];
      wr(6'h04, 32'h300);
      wait_idle(1);
      check(err[1] == 1, "R8 misaligned tx", err[1], 1);
      wr(6'h14, 32'h1);
      wait_idle(0);
      check(err[0] == 1, "R8 misaligned rx", err[0], 1);
      wr(6'h04, 32'h400);
      wait_idle(1);
      check(err[1] == 1, "R8 invalid tx", err[1], 1);
      check(done_cnt[1] == d1 && done_cnt[0] == d0, "R8 no done", done_cnt[1], d1);
      wr(6'h04, 32'h200);
      check(err[1] == 0, "R8 err cleared on start", err[1], 0);
      check(err[0] == 1, "R8 rx err held", err[0], 1);
      wait_idle(1);

      // R11 pointer write during walk ignored; R7 last without transfer
      mem_lat = '{1, 2}; ack_lat = '{2, 3};
      x1 = xfer_cnt[1]; d1 = done_cnt[1]; x0 = xfer_cnt[0]; d0 = done_cnt[0];
      wr(6'h04, 32'h500);
      repeat (3) @(negedge clk);
      wr(6'h04, 32'h600);
      wait_idle(1);
      check(xfer_cnt[1] - x1 == 5, "R11 tx walk unchanged", xfer_cnt[1] - x1, 5);
      check(done_cnt[1] - d1 == 1, "R11 tx one done", done_cnt[1] - d1, 1);
      wr(6'h14, 32'h1);
      wait_idle(0);
      check(xfer_cnt[0] == x0 && done_cnt[0] - d0 == 1, "R7 last without transfer", done_cnt[0] - d0, 1);

      // R9 receive stop during walk
      x0 = xfer_cnt[0]; d0 = done_cnt[0];
      wr(6'h04, 32'h500);
      wr(6'h14, 32'h1);
      repeat (7) @(negedge clk);
      wr(6'h14, 32'h0);
      check(busy[0] == 0, "R9 rx stopped", busy[0], 0);
      check(busy[1] == 1, "R9 tx unaffected", busy[1], 1);
      repeat (10) @(negedge clk);
      check(done_cnt[0] == d0 && err[0] == 0, "R9 no done no err", done_cnt[0] - d0, 0);
      wait_idle(1);

      // R8 unmapped descriptor reads as invalid
      wr(6'h04, 32'h900);
      wait_idle(1);
      check(err[1] == 1, "R8 unmapped", err[1], 1);

      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule